// File: doc/BRIEF.md
# Masked 4-bit Inversion S-Box

This block evaluates a 4-bit nonlinear substitution on a secret value that never appears in the clear. The value arrives as ORDER+1 Boolean shares whose XOR is the secret. The block raises it to the 14th power in GF(2^4), which gives the field inverse and sends zero to zero. It then applies a cyclic affine map. The result leaves as ORDER+1 output shares whose XOR is the substituted value. ORDER, the masking order, is a parameter from 1 to 3.

The inverse is produced by a fixed 13-step sequence. One share-wise squarer, one mask refresh stage and one ISW-style share multiplier take turns on a small set of registered operands. A caller pulses `start` with the input shares, keeps fresh random words on `rnd` on every cycle, and reads `out_shares` when `done` pulses. The output shares then stay put until the next result.

Top module: `masked_gf16_sbox`

## Requirements
- R1: With field arithmetic modulo x^4+x+1 and inv(a)=a^14, the XOR of the output shares equals Q ^ (inv(a)·P mod X^4+1), where a is the XOR of the input shares, P=4'hB and Q=4'hD. The product is cyclic, so bit k of P selects the operand rotated left by k.
- R2: Taken in input order 0 to F, the unmasked results are D,6,B,9,5,C,F,4,2,A,E,8,7,3,1,0; in particular input 0 gives D.
- R3: `done` rises exactly 13 clock edges after the edge at which a start is accepted. A start is accepted when `start` is high and no evaluation is in progress.
- R4: `done` is high for one cycle per accepted start.
- R5: `start` while an evaluation is in progress is ignored: the evaluation is neither restarted nor lengthened, and it yields no extra `done`.
- R6: `out_shares` changes only in the cycle that `done` is high, and otherwise holds the last result.
- R7: While `rst` is high at a clock edge, `done` and `out_shares` are zero after that edge.
- R8: R1 holds for ORDER = 1, 2 and 3 and for any values on `rnd` (2·ORDER·(ORDER+1) bits: one 4-bit word per share pair).
- R9: The same input shares evaluated repeatedly under different random words give output share vectors that are not all equal.
- R10: A new start may be accepted in the cycle `done` is high. With `start` held high, one result is produced every 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an evaluation of `in_shares` |
| in_shares | input | 4*(ORDER+1) | Input shares, share i in bits [4i+3:4i] |
| rnd | input | 2*ORDER*(ORDER+1) | Fresh random words, sampled during the evaluation |
| done | output | 1 | One-cycle pulse when `out_shares` holds a new result |
| out_shares | output | 4*(ORDER+1) | Output shares, share i in bits [4i+3:4i] |

## Verification
The bench targets input zero, the one value with no true inverse. A design that inverted zero by any means other than the power chain, or that left the affine constant out, would return something other than D. It holds `start` high across whole evaluations and back-to-back boundaries. A controller that restarted on a busy start, or that dropped the start arriving with `done`, would shift or lose pulses against the 14-cycle cadence. It runs the three masking orders side by side with live random words. A pair-index or cross-term ordering error in the share multiplier would corrupt the recombined value for some orders only. It also repeats one input to show that the random words actually reach the outputs.

// File: rtl/msbox_pkg.sv
package msbox_pkg;

    localparam logic [3:0] AFF_P     = 4'hB;
    localparam logic [3:0] AFF_Q     = 4'hD;
    localparam logic [3:0] LAST_STEP = 4'd13;

    typedef enum logic [1:0] {
        SRC_IN  = 2'd0,
        SRC_MUL = 2'd1,
        SRC_SQ  = 2'd2
    } sq_src_e;

    typedef struct packed {
        logic    sq_ld;
        sq_src_e sq_src;
        logic    sq_ev;
        logic    rf_ev;
        logic    mul_ld;
        logic    mul_a_sq;
        logic    mul_mid;
        logic    mul_cmp;
        logic    emit;
    } step_t;

    // multiply in GF(2^4) modulo x^4+x+1
    function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc;
        logic [3:0] t;
        acc = 4'h0;
        t   = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ t;
            t = {t[2:0], 1'b0} ^ (t[3] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    function automatic logic [3:0] gf_sq(input logic [3:0] a);
        return gf_mul(a, a);
    endfunction

    // polynomial product modulo X^4+1 (cyclic)
    function automatic logic [3:0] cyc_mul(input logic [3:0] a, input logic [3:0] p);
        logic [3:0] acc;
        logic [7:0] w;
        acc = 4'h0;
        for (int i = 0; i < 4; i++) begin
            w = {a, a} << i;
            if (p[i]) acc = acc ^ w[7:4];
        end
        return acc;
    endfunction

    function automatic logic [3:0] gf_pow14(input logic [3:0] a);
        logic [3:0] r;
        r = 4'h1;
        for (int i = 0; i < 14; i++) r = gf_mul(r, a);
        return r;
    endfunction

    function automatic logic [3:0] sbox_ref(input logic [3:0] a);
        return cyc_mul(gf_pow14(a), AFF_P) ^ AFF_Q;
    endfunction

    // index of the random word for share pair (i,j), i<j, n shares
    function automatic int pair_idx(input int i, input int j, input int n);
        return (i * (2 * n - i - 1)) / 2 + (j - i - 1);
    endfunction

    function automatic step_t decode_step(input logic accept, input logic busy,
                                          input logic [3:0] cnt);
        step_t s;
        s = '0;
        s.sq_src = SRC_IN;
        if (accept) begin
            s.sq_ld = 1'b1;
        end else if (busy) begin
            case (cnt)
                4'd1:  s.sq_ev   = 1'b1;
                4'd2:  s.rf_ev   = 1'b1;
                4'd3:  s.mul_ld  = 1'b1;
                4'd4:  s.mul_mid = 1'b1;
                4'd5:  s.mul_cmp = 1'b1;
                4'd6:  begin s.sq_ld = 1'b1; s.sq_src = SRC_MUL; end
                4'd7:  s.sq_ev   = 1'b1;
                4'd8:  begin s.sq_ld = 1'b1; s.sq_src = SRC_SQ; end
                4'd9:  s.sq_ev   = 1'b1;
                4'd10: begin s.mul_ld = 1'b1; s.mul_a_sq = 1'b1; end
                4'd11: s.mul_mid = 1'b1;
                4'd12: s.mul_cmp = 1'b1;
                4'd13: s.emit    = 1'b1;
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/msbox_sq.sv
module msbox_sq #(
    parameter int NSH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld,
    input  logic                 ev,
    input  logic [NSH-1:0][3:0]  din,
    output logic [NSH-1:0][3:0]  dout
);
    import msbox_pkg::*;

    logic [NSH-1:0][3:0] in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
            dout <= '0;
        end else begin
            if (ld) in_q <= din;
            if (ev) begin
                for (int i = 0; i < NSH; i++) dout[i] <= gf_sq(in_q[i]);
            end
        end
    end
endmodule

// File: rtl/msbox_refresh.sv
module msbox_refresh #(
    parameter int ORDER = 2,
    localparam int NSH = ORDER + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev,
    input  logic [NSH-1:0][3:0]   din,
    input  logic [ORDER-1:0][3:0] rw,
    output logic [NSH-1:0][3:0]   dout
);
    logic [3:0] mix;

    always_comb begin
        mix = 4'h0;
        for (int i = 0; i < ORDER; i++) mix = mix ^ rw[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (ev) begin
            for (int i = 0; i < ORDER; i++) dout[i] <= din[i] ^ rw[i];
            dout[ORDER] <= din[ORDER] ^ mix;
        end
    end
endmodule

// File: rtl/msbox_isw_mul.sv
module msbox_isw_mul #(
    parameter int NSH = 3,
    localparam int NPAIR = NSH * (NSH - 1) / 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld,
    input  logic                   mid,
    input  logic                   cmp,
    input  logic [NSH-1:0][3:0]    a_in,
    input  logic [NSH-1:0][3:0]    b_in,
    input  logic [NPAIR-1:0][3:0]  rw,
    output logic [NSH-1:0][3:0]    c_out
);
    import msbox_pkg::*;

    logic [NSH-1:0][3:0]           xa_q, xb_q;
    logic [NSH-1:0][3:0]           diag_q, diag_d;
    logic [NSH-1:0][NSH-1:0][3:0]  z_q, z_d;
    logic [NSH-1:0][3:0]           c_d;

    always_comb begin
        z_d    = '0;
        diag_d = '0;
        for (int i = 0; i < NSH; i++) begin
            diag_d[i] = gf_mul(xa_q[i], xb_q[i]);
            for (int j = 0; j < NSH; j++) begin
                if (i < j) begin
                    z_d[i][j] = rw[pair_idx(i, j, NSH)];
                end else if (i > j) begin
                    z_d[i][j] = (rw[pair_idx(j, i, NSH)] ^ gf_mul(xa_q[j], xb_q[i]))
                                ^ gf_mul(xa_q[i], xb_q[j]);
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NSH; i++) begin
            c_d[i] = diag_q[i];
            for (int j = 0; j < NSH; j++) c_d[i] = c_d[i] ^ z_q[i][j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xa_q   <= '0;
            xb_q   <= '0;
            diag_q <= '0;
            z_q    <= '0;
            c_out  <= '0;
        end else begin
            if (ld) begin
                xa_q <= a_in;
                xb_q <= b_in;
            end
            if (mid) begin
                diag_q <= diag_d;
                z_q    <= z_d;
            end
            if (cmp) c_out <= c_d;
        end
    end
endmodule

// File: rtl/masked_gf16_sbox.sv
module masked_gf16_sbox #(
    parameter int ORDER = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [4*(ORDER+1)-1:0]        in_shares,
    input  logic [2*ORDER*(ORDER+1)-1:0]  rnd,
    output logic                          done,
    output logic [4*(ORDER+1)-1:0]        out_shares
);
    import msbox_pkg::*;

    localparam int NSH   = ORDER + 1;
    localparam int NPAIR = NSH * ORDER / 2;

    typedef logic [NSH-1:0][3:0] shv_t;

    shv_t  in_v, a_q, sq_din, sq_val, rf_val, mul_a, mul_val, out_q;
    logic [NPAIR-1:0][3:0] rnd_v;
    logic  busy;
    logic  accept;
    logic [3:0] cnt;
    step_t st;

    assign in_v   = in_shares;
    assign rnd_v  = rnd;
    assign accept = start & ~busy;
    assign st     = decode_step(accept, busy, cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= 4'd0;
            done <= 1'b0;
            a_q  <= '0;
        end else begin
            done <= st.emit;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= 4'd1;
                a_q  <= in_v;
            end else if (busy) begin
                if (cnt == LAST_STEP) begin
                    busy <= 1'b0;
                    cnt  <= 4'd0;
                end else begin
                    cnt <= cnt + 4'd1;
                end
            end
        end
    end

    always_comb begin
        case (st.sq_src)
            SRC_MUL: sq_din = mul_val;
            SRC_SQ:  sq_din = sq_val;
            default: sq_din = in_v;
        endcase
    end

    assign mul_a = st.mul_a_sq ? sq_val : a_q;

    msbox_sq #(.NSH(NSH)) u_sq (
        .clk  (clk),
        .rst  (rst),
        .ld   (st.sq_ld),
        .ev   (st.sq_ev),
        .din  (sq_din),
        .dout (sq_val)
    );

    msbox_refresh #(.ORDER(ORDER)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ev   (st.rf_ev),
        .din  (sq_val),
        .rw   (rnd_v[ORDER-1:0]),
        .dout (rf_val)
    );

    msbox_isw_mul #(.NSH(NSH)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .ld    (st.mul_ld),
        .mid   (st.mul_mid),
        .cmp   (st.mul_cmp),
        .a_in  (mul_a),
        .b_in  (rf_val),
        .rw    (rnd_v),
        .c_out (mul_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (st.emit) begin
            for (int i = 0; i < NSH; i++)
                out_q[i] <= cyc_mul(mul_val[i], AFF_P) ^ ((i == 0) ? AFF_Q : 4'h0);
        end
    end

    assign out_shares = out_q;

endmodule

// File: rtl/masked_gf16_sbox_chk.sv
module masked_gf16_sbox_chk #(
    parameter int ORDER = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [4*(ORDER+1)-1:0]  in_shares,
    input logic [4*(ORDER+1)-1:0]  out_shares
);
    import msbox_pkg::*;

    function automatic logic [3:0] fold(input logic [4*(ORDER+1)-1:0] v);
        logic [3:0] acc;
        acc = 4'h0;
        for (int i = 0; i <= ORDER; i++) acc = acc ^ v[4*i +: 4];
        return acc;
    endfunction

    logic [3:0] lat;
    logic [3:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat  <= 4'd0;
            want <= 4'h0;
        end else if (start && !busy) begin
            lat  <= 4'd13;
            want <= sbox_ref(fold(in_shares));
        end else if (lat != 4'd0) begin
            lat <= lat - 4'd1;
        end
    end

    // R1
    value_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> fold(out_shares) == want);

    // R3
    latency_reach_chk: assert property (@(posedge clk) disable iff (rst)
        (lat == 4'd1) |=> done);

    // R3
    latency_exact_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(lat) == 4'd1);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && lat != 4'd1) |=> busy);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_shares) |-> done);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && out_shares == '0));

endmodule

bind masked_gf16_sbox masked_gf16_sbox_chk #(.ORDER(ORDER)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .in_shares  (in_shares),
    .out_shares (out_shares)
);

// File: tb/masked_gf16_sbox_tb.sv
module sbox_harness #(
    parameter int ORDER = 1
) (
    input  logic clk,
    input  logic rst,
    output int   checks,
    output int   fails,
    output logic fin
);
    localparam int SW = 4 * (ORDER + 1);
    localparam int RW = 2 * ORDER * (ORDER + 1);

    logic          start;
    logic [SW-1:0] in_shares;
    logic [RW-1:0] rnd;
    logic          done;
    logic [SW-1:0] out_shares;

    masked_gf16_sbox #(.ORDER(ORDER)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .in_shares  (in_shares),
        .rnd        (rnd),
        .done       (done),
        .out_shares (out_shares)
    );

    // R2 table, input order 0..F
    logic [3:0] tab [16] = '{4'hD, 4'h6, 4'hB, 4'h9, 4'h5, 4'hC, 4'hF, 4'h4,
                             4'h2, 4'hA, 4'hE, 4'h8, 4'h7, 4'h3, 4'h1, 4'h0};

    int ck_a = 0, fl_a = 0, ck_b = 0, fl_b = 0;
    assign checks = ck_a + ck_b;
    assign fails  = fl_a + fl_b;

    function automatic logic [3:0] fold(input logic [SW-1:0] v);
        logic [3:0] acc;
        acc = 4'h0;
        for (int i = 0; i <= ORDER; i++) acc = acc ^ v[4*i +: 4];
        return acc;
    endfunction

    function automatic logic [SW-1:0] make_sh(input logic [3:0] v);
        logic [SW-1:0] s;
        logic [3:0]    acc;
        acc = 4'h0;
        s   = '0;
        for (int i = 0; i < ORDER; i++) begin
            s[4*i +: 4] = 4'($urandom);
            acc = acc ^ s[4*i +: 4];
        end
        s[4*ORDER +: 4] = v ^ acc;
        return s;
    endfunction

    // reference model: queue of pending (value, input) pairs
    int         m_cnt;
    logic       m_busy;
    logic       exp_done;
    logic [3:0] exp_val;
    logic [3:0] exp_in;
    logic [7:0] pend_q[$];
    logic [SW-1:0] held;
    logic [SW-1:0] last_out;
    int         n_done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy   = 1'b0;
            m_cnt    = 0;
            exp_done = 1'b0;
            pend_q.delete();
        end else begin
            exp_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy   = 1'b0;
                    exp_done = 1'b1;
                    {exp_in, exp_val} = pend_q.pop_front();
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_cnt  = 13;
                pend_q.push_back({fold(in_shares), tab[fold(in_shares)]});
            end
        end
    end

    always @(negedge clk) begin
        rnd <= RW'({$urandom, $urandom});
        if (rst) begin
            held <= '0;
        end else begin
            ck_a++;
            if (done !== exp_done) begin
                fl_a++;
                $display("FAIL R3/R4/R5 order=%0d done=%b expected=%b", ORDER, done, exp_done);
            end
            if (exp_done) begin
                ck_a++;
                if (fold(out_shares) !== exp_val) begin
                    fl_a++;
                    if (exp_in == 4'h0)
                        $display("FAIL R2 order=%0d in=0 got=%h expected=%h", ORDER, fold(out_shares), exp_val);
                    else
                        $display("FAIL R1/R8 order=%0d in=%h got=%h expected=%h", ORDER, exp_in, fold(out_shares), exp_val);
                end
                held     <= out_shares;
                last_out <= out_shares;
                n_done   <= n_done + 1;
            end else begin
                ck_a++;
                if (out_shares !== held) begin
                    fl_a++;
                    $display("FAIL R6 order=%0d out=%h expected=%h", ORDER, out_shares, held);
                end
            end
        end
    end

    task automatic run_one(input logic [SW-1:0] sh);
        start     = 1'b1;
        in_shares = sh;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        logic [SW-1:0] first;
        logic [SW-1:0] fix;
        int base;
        bit differ;
        start     = 1'b0;
        in_shares = '0;
        fin       = 1'b0;
        repeat (3) @(negedge clk);
        ck_b++;
        if (done !== 1'b0 || out_shares !== '0) begin
            fl_b++;
            $display("FAIL R7 order=%0d done=%b out=%h expected done=0 out=0", ORDER, done, out_shares);
        end
        while (rst) @(negedge clk);
        @(negedge clk);

        // every input value, R1 and R2
        for (int v = 0; v < 16; v++) run_one(make_sh(4'(v)));

        // R10: start held high through three evaluations
        base      = n_done;
        start     = 1'b1;
        in_shares = make_sh(4'($urandom));
        for (int k = 0; k < 29; k++) begin
            @(negedge clk);
            in_shares = make_sh(4'($urandom));
        end
        start = 1'b0;
        repeat (20) @(negedge clk);
        ck_b++;
        if (n_done - base != 3) begin
            fl_b++;
            $display("FAIL R10 order=%0d results=%0d expected=3", ORDER, n_done - base);
        end

        // R9: same shares, different random words
        fix = make_sh(4'h7);
        run_one(fix);
        first  = last_out;
        differ = 1'b0;
        for (int k = 0; k < 4; k++) begin
            run_one(fix);
            if (last_out !== first) differ = 1'b1;
        end
        ck_b++;
        if (!differ) begin
            fl_b++;
            $display("FAIL R9 order=%0d out=%h for every run, expected variation", ORDER, first);
        end

        for (int k = 0; k < 40; k++) run_one(make_sh(4'($urandom)));
        repeat (5) @(negedge clk);
        fin = 1'b1;
    end
endmodule

module masked_gf16_sbox_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int   c1, c2, c3, f1, f2, f3;
    logic d1, d2, d3;
    int   cycles = 0;
    int   wd_fail = 0;

    always #4 clk = ~clk;

    sbox_harness #(.ORDER(1)) h1 (.clk(clk), .rst(rst), .checks(c1), .fails(f1), .fin(d1));
    sbox_harness #(.ORDER(2)) h2 (.clk(clk), .rst(rst), .checks(c2), .fails(f2), .fin(d2));
    sbox_harness #(.ORDER(3)) h3 (.clk(clk), .rst(rst), .checks(c3), .fails(f3), .fin(d3));

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        repeat (6) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        while (!(d1 && d2 && d3) && cycles < 50000) @(negedge clk);
        if (!(d1 && d2 && d3)) begin
            wd_fail = 1;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cycles);
        end
        $display("TB_RESULT checks=%0d failures=%0d", c1 + c2 + c3 + wd_fail, f1 + f2 + f3 + wd_fail);
        $finish;
    end
endmodule